// File: doc/BRIEF.md
# Chainable Sixteen-Line Priority Encoder

This block turns a set of request lines into the binary index of the most urgent line that is asserted. The higher the line number, the higher its priority. Each encoder lane takes eight lines and has three outputs. An `en_in` qualifier enables the lane. A `hit` flag reports that at least one line in the lane is asserted. A `pass_en` output carries permission on to a lane of lower rank, so lanes can be chained without any extra arbitration gates.

The top level chains two lanes. The upper lane covers lines 15 to 8 and the lower lane covers lines 7 to 0. The upper lane's `pass_en` feeds the lower lane's `en_in`. This means the lower lane only reports a result when nothing above it is asserted. The three low bits of the result are the OR of both lanes' indices, and the upper lane's `hit` supplies the most significant bit. Every output is a combinational function of the inputs. The block has no clock, no state and no reset.

Top module: `prio_enc_chain`

## Requirements
- R1: When a lane's enable input is 0, its index, hit flag and pass-on enable are all 0, whatever its request lines hold.
- R2: When a lane is enabled and none of its request lines is 1, its index is 0, its hit flag is 0 and its pass-on enable is 1.
- R3: When a lane is enabled and at least one request line is 1, its hit flag is 1 and its pass-on enable is 0.
- R4: An enabled lane with any request reports, as an unsigned binary index, the number of the highest-numbered request line at 1. Line 7 is the most urgent and line 0 the least.
- R5: In the chain, the lower lane (lines 7..0) is enabled only through the upper lane's pass-on enable. Any request on lines 15..8 therefore silences the lower lane completely.
- R6: With `en_in`=1 and at least one request, `idx` is the number (0..15) of the highest-numbered request line at 1. Bit 3 of `idx` is 1 exactly when some line in 15..8 is asserted.
- R7: The chain's `any_hit` is 1 exactly when it is enabled and some request is 1. Its `pass_en` is 1 exactly when it is enabled and all sixteen requests are 0. The two are never 1 together.
- R8: With `en_in`=0 the chain drives `idx`=0, `any_hit`=0 and `pass_en`=0 for every request pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_in | input | 1 | Enable for the whole chain (feeds the upper lane) |
| req | input | 16 | Request lines; bit 15 is the most urgent |
| idx | output | 4 | Index of the most urgent asserted line |
| any_hit | output | 1 | At least one line asserted while enabled |
| pass_en | output | 1 | Enable for a further lane of lower rank |

## Verification
The hardest situation to reach from the ports is a conflict between the two lanes. It occurs when requests are present in both halves at once, so that the lower lane holds candidates that must stay hidden. It also occurs when only the lower half is active and the OR merge must bring its index through unchanged. The stimulus sweeps every single-line pattern and every pairing of one upper line with one lower line. It then adds pseudo-random patterns with dense lower halves. A separate lane instance is swept over all 512 combinations of enable and its eight lines.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;
    parameter int unsigned LANE_W  = 8;
    parameter int unsigned N_LANES = 2;
    localparam int unsigned LANE_AW = $clog2(LANE_W);
endpackage

// File: rtl/prio_lane.sv
module prio_lane #(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned AW = $clog2(WIDTH)
) (
    input  logic             en_in,
    input  logic [WIDTH-1:0] req,
    output logic [AW-1:0]    addr,
    output logic             hit,
    output logic             pass_en
);
    // Ascending scan: a later (higher) line overrides, so the highest wins.
    always_comb begin
        addr    = '0;
        hit     = 1'b0;
        pass_en = 1'b0;
        if (en_in) begin
            pass_en = 1'b1;
            for (int i = 0; i < WIDTH; i++) begin
                if (req[i]) begin
                    addr    = AW'(i);
                    hit     = 1'b1;
                    pass_en = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/prio_merge.sv
module prio_merge #(
    parameter int unsigned NL = 2,
    parameter int unsigned AW = 3
) (
    input  logic [NL-1:0][AW-1:0] lane_addr,
    input  logic [NL-1:0]         lane_hit,
    output logic [AW-1:0]         addr_or,
    output logic                  hit_or
);
    always_comb begin
        addr_or = '0;
        hit_or  = 1'b0;
        for (int k = 0; k < NL; k++) begin
            addr_or = addr_or | lane_addr[k];
            hit_or  = hit_or | lane_hit[k];
        end
    end
endmodule

// File: rtl/prio_enc_chain.sv
module prio_enc_chain
    import prio_enc_pkg::*;
#(
    parameter int unsigned STAGE_W = LANE_W,
    localparam int unsigned NST    = N_LANES,
    localparam int unsigned TOT_W  = NST * STAGE_W,
    localparam int unsigned SAW    = $clog2(STAGE_W),
    localparam int unsigned TAW    = SAW + 1
) (
    input  logic             en_in,
    input  logic [TOT_W-1:0] req,
    output logic [TAW-1:0]   idx,
    output logic             any_hit,
    output logic             pass_en
);
    // lane 0 is the upper (most urgent) lane
    logic [NST-1:0][SAW-1:0] st_addr;
    logic [NST-1:0]          st_hit;
    logic [NST:0]            chain;
    logic [SAW-1:0]          low_bits;

    assign chain[0] = en_in;

    for (genvar s = 0; s < NST; s++) begin : g_lane
        prio_lane #(.WIDTH(STAGE_W)) u_lane (
            .en_in   (chain[s]),
            .req     (req[TOT_W-1-s*STAGE_W -: STAGE_W]),
            .addr    (st_addr[s]),
            .hit     (st_hit[s]),
            .pass_en (chain[s+1])
        );
    end

    prio_merge #(.NL(NST), .AW(SAW)) u_merge (
        .lane_addr (st_addr),
        .lane_hit  (st_hit),
        .addr_or   (low_bits),
        .hit_or    (any_hit)
    );

    assign idx     = {st_hit[0], low_bits};
    assign pass_en = chain[NST];
endmodule

// File: rtl/prio_enc_chain_chk.sv
module prio_enc_chain_chk #(
    parameter int unsigned TOT_W = 16,
    parameter int unsigned TAW   = 4,
    parameter int unsigned SAW   = 3
) (
    input logic             en_in,
    input logic [TOT_W-1:0] req,
    input logic [TAW-1:0]   idx,
    input logic             any_hit,
    input logic             pass_en,
    input logic [SAW-1:0]   lo_addr,
    input logic             lo_hit,
    input logic             lo_en
);
    always_comb begin
        if (!en_in) AST_OFF_QUIET: assert (idx == '0 && !any_hit && !pass_en); // R8
        AST_HIT_PASS_EXCL: assert (!(any_hit && pass_en)); // R7
        if (any_hit) AST_IDX_LIVE: assert (req[idx]); // R6
        if (idx[TAW-1]) AST_TOP_BIT_SRC: assert (|req[TOT_W-1:TOT_W/2]); // R6
        if (|req[TOT_W-1:TOT_W/2]) AST_LOWER_MUTED: assert (!lo_en && !lo_hit && lo_addr == '0); // R5
        if (lo_hit) AST_LOWER_ONLY: assert (req[TOT_W/2-1:0] != '0 && en_in); // R3
    end
endmodule

bind prio_enc_chain prio_enc_chain_chk #(.TOT_W(TOT_W), .TAW(TAW), .SAW(SAW)) u_chk (
    .en_in   (en_in),
    .req     (req),
    .idx     (idx),
    .any_hit (any_hit),
    .pass_en (pass_en),
    .lo_addr (st_addr[NST-1]),
    .lo_hit  (st_hit[NST-1]),
    .lo_en   (chain[NST-1])
);

// File: tb/prio_enc_chain_tb.sv
module prio_enc_chain_tb;
    logic        clk = 1'b0;
    logic        en_in;
    logic [15:0] req;
    logic [3:0]  idx;
    logic        any_hit, pass_en;
    logic        l_en;
    logic [7:0]  l_req;
    logic [2:0]  l_addr;
    logic        l_hit, l_pass;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    prio_enc_chain u_dut (.en_in(en_in), .req(req), .idx(idx), .any_hit(any_hit), .pass_en(pass_en));
    prio_lane #(.WIDTH(8)) u_stage (.en_in(l_en), .req(l_req), .addr(l_addr), .hit(l_hit), .pass_en(l_pass));

    function automatic logic [5:0] ref16(input logic e, input logic [15:0] v);
        logic [3:0] ix; logic h;
        ix = '0; h = 1'b0;
        if (e) for (int i = 15; i >= 0; i--) if (!h && v[i]) begin ix = 4'(i); h = 1'b1; end
        return {ix, h, e && !h};
    endfunction

    function automatic logic [4:0] ref8(input logic e, input logic [7:0] v);
        logic [2:0] ix; logic h;
        ix = '0; h = 1'b0;
        if (e) for (int i = 7; i >= 0; i--) if (!h && v[i]) begin ix = 3'(i); h = 1'b1; end
        return {ix, h, e && !h};
    endfunction

    task automatic apply16(input logic e, input logic [15:0] v, input string tag);
        logic [5:0] exp;
        @(negedge clk); en_in = e; req = v;
        #1;
        exp = ref16(e, v);
        n_chk++;
        if ({idx, any_hit, pass_en} !== exp) begin
            n_err++;
            $display("FAIL %s en=%b req=%h got idx=%0d hit=%b pass=%b exp idx=%0d hit=%b pass=%b",
                     tag, e, v, idx, any_hit, pass_en, exp[5:2], exp[1], exp[0]);
        end
    endtask

    task automatic t_lane_exhaustive; // R1 R2 R3 R4
        for (int c = 0; c < 512; c++) begin
            logic [4:0] exp;
            @(negedge clk); l_en = c[8]; l_req = c[7:0];
            #1;
            exp = ref8(c[8], c[7:0]);
            n_chk++;
            if ({l_addr, l_hit, l_pass} !== exp) begin
                n_err++;
                $display("FAIL R1/R2/R3/R4 lane en=%b req=%h got %b exp %b", c[8], c[7:0],
                         {l_addr, l_hit, l_pass}, exp);
            end
        end
    endtask

    task automatic t_disabled; // R8
        apply16(1'b0, 16'h0000, "R8");
        apply16(1'b0, 16'hFFFF, "R8");
        apply16(1'b0, 16'h8001, "R8");
        apply16(1'b0, 16'h00A5, "R8");
    endtask

    task automatic t_zero; // R7
        apply16(1'b1, 16'h0000, "R7");
    endtask

    task automatic t_onehot; // R6
        for (int i = 0; i < 16; i++) apply16(1'b1, 16'(1) << i, "R6");
    endtask

    task automatic t_pairs; // R5
        for (int u = 8; u < 16; u++)
            for (int l = 0; l < 8; l++)
                apply16(1'b1, (16'(1) << u) | (16'(1) << l), "R5");
    endtask

    task automatic t_random; // R6 R7
        logic [31:0] s;
        s = 32'h1234_5678;
        for (int n = 0; n < 300; n++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            if (n % 3 == 0) apply16(1'b1, {8'h00, s[23:16]}, "R6");
            else if (n % 3 == 1) apply16(1'b1, {s[31:24] & s[15:8], 8'hFF}, "R5");
            else apply16(s[5], s[31:16], "R7");
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        en_in = 1'b0; req = '0; l_en = 1'b0; l_req = '0;
        t_disabled();
        t_zero();
        t_lane_exhaustive();
        t_onehot();
        t_pairs();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule